// File: doc/BRIEF.md
# Text-Mode Character and Color Buffer

This block is the storage half of a character-cell display controller. The screen is a grid of 100 columns by 75 rows, 7500 cells in all. Each cell keeps an 8-bit character code in a character plane and a 4-bit color (one of 16) in a separate color plane. The processor reaches the planes only by writing. A store whose address falls in the character window, starting at 0xC000, sets one character byte. A store whose address falls in the color window, starting at 0xE000, sets one color nibble. In both windows the cell number is the address minus the window base. The processor has no read path into either plane.

A second port serves the raster scanner and is independent of the write port. The scanner presents a column and a row. One clock later the block returns the character code and the color of that cell. The cell number is row times 100 plus column, so a store at window offset N is the cell at column N mod 100 and row N div 100. Reset clears only the scan output registers. The plane contents survive reset and are undefined until written.

No state machine is needed. The write decoder classifies every bus cycle into one of three windows: `WIN_NONE` (no store, or an address outside both windows), `WIN_TEXT` or `WIN_COLOR`. The scan side is a single registered read stage.

Top module: `txtbuf_top`

## Requirements
- R1: A store with `wr_en`=1 to an address A with 0xC000 <= A <= 0xDD4B writes `wr_data` into the character byte of cell A-0xC000. That cell is scanned at column (A-0xC000) mod 100, row (A-0xC000) div 100, and the last address, 0xDD4B, is column 99, row 74.
- R2: A store to an address A with 0xE000 <= A <= 0xFD4B writes `wr_data[3:0]` into the color of cell A-0xE000, and `wr_data[7:4]` is dropped.
- R3: A store to any other address leaves both planes unchanged, including 0xBFFF, 0xDD4C, 0xDFFF, 0xFD4C and addresses that differ from a window only above bit 15.
- R4: The scan outputs `scan_char` and `scan_color` show the cell numbered `scan_row`*100+`scan_col` as sampled at one rising edge, and hold that value until the next edge.
- R5: A character store does not alter any color, and a color store does not alter any character.
- R6: When a store and a scan hit the same cell in the same cycle, that scan returns the previous content, and the next scan of the cell returns the new content.
- R7: A scan with `scan_col` >= 100 or `scan_row` >= 75 returns character 0 and color 0 one clock later.
- R8: While `rst_n` is low, both scan outputs are 0. Reset does not clear either plane, so cells written before a reset read back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low reset of the scan output registers |
| wr_en | input | 1 | Store strobe from the processor bus |
| wr_addr | input | 32 | Store byte address |
| wr_data | input | 8 | Store data: a character, or a color in bits 3:0 |
| scan_col | input | 7 | Column requested by the raster scanner |
| scan_row | input | 7 | Row requested by the raster scanner |
| scan_char | output | 8 | Character code of the requested cell, one clock later |
| scan_color | output | 4 | Color of the requested cell, one clock later |

## Verification
Both planes are filled with distinct values that come from the cell number, and all 7500 cells are then scanned in raster order. A wrong column or row weighting, or an offset error in either window, shows up as a mismatch. A second scan uses a coprime stride across the grid, so results that only hold for sequential access are caught. Stores aimed just outside each window edge, and at aliases above bit 15, separate a full address compare from a truncated one. Color data with the high nibble set, single-plane overwrites, a same-cycle store and scan, out-of-range coordinates and a mid-run reset each probe one rule that the raster sweep cannot.

// File: rtl/txtbuf_pkg.sv
package txtbuf_pkg;

    // Which window a bus cycle lands in
    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_TEXT  = 2'd1,
        WIN_COLOR = 2'd2
    } win_e;

    localparam int unsigned DEF_COLS     = 100;
    localparam int unsigned DEF_ROWS     = 75;
    localparam int unsigned DEF_ADDR_W   = 32;
    localparam int unsigned DEF_CHAR_W   = 8;
    localparam int unsigned DEF_COLOR_W  = 4;

endpackage

// File: rtl/txtbuf_decode.sv
module txtbuf_decode
    import txtbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CELLS  = 7500,
    parameter int unsigned IDX_W  = $clog2(CELLS),
    parameter logic [ADDR_W-1:0] TXT_BASE = 'h0000C000,
    parameter logic [ADDR_W-1:0] CLR_BASE = 'h0000E000
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              txt_we,
    output logic              clr_we,
    output logic [IDX_W-1:0]  cell_off
);

    localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(CELLS);
    localparam logic [ADDR_W-1:0] TXT_END = TXT_BASE + SPAN;
    localparam logic [ADDR_W-1:0] CLR_END = CLR_BASE + SPAN;

    win_e win;

    // Full-width compare: aliases above the window are rejected
    always_comb begin
        win = WIN_NONE;
        if (wr_en) begin
            if (wr_addr >= TXT_BASE && wr_addr < TXT_END) begin
                win = WIN_TEXT;
            end else if (wr_addr >= CLR_BASE && wr_addr < CLR_END) begin
                win = WIN_COLOR;
            end
        end
    end

    always_comb begin
        txt_we   = 1'b0;
        clr_we   = 1'b0;
        cell_off = '0;
        unique case (win)
            WIN_TEXT: begin
                txt_we   = 1'b1;
                cell_off = IDX_W'(wr_addr - TXT_BASE);
            end
            WIN_COLOR: begin
                clr_we   = 1'b1;
                cell_off = IDX_W'(wr_addr - CLR_BASE);
            end
            default: ;
        endcase
    end

    always_comb begin
        assert_one_plane_R5: assert (!(txt_we && clr_we))
            else $error("store reached both planes");
    end

endmodule

// File: rtl/txtbuf_plane.sv
module txtbuf_plane #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 7500,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Read-first: a same-cycle store is seen on the following read
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

    assert_store_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < (IDX_W+1)'(DEPTH)))
        else $error("store offset beyond plane depth");

    assert_store_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we ##1 (raddr == $past(waddr)) |=> (rdata == $past(wdata, 2)))
        else $error("stored value not returned by later read");

endmodule

// File: rtl/txtbuf_top.sv
module txtbuf_top
    import txtbuf_pkg::*;
#(
    parameter int unsigned COLS    = DEF_COLS,
    parameter int unsigned ROWS    = DEF_ROWS,
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned CHAR_W  = DEF_CHAR_W,
    parameter int unsigned COLOR_W = DEF_COLOR_W,
    parameter logic [ADDR_W-1:0] TXT_BASE = 'h0000C000,
    parameter logic [ADDR_W-1:0] CLR_BASE = 'h0000E000,
    parameter int unsigned COL_W   = $clog2(COLS),
    parameter int unsigned ROW_W   = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CHAR_W-1:0]  wr_data,
    input  logic [COL_W-1:0]   scan_col,
    input  logic [ROW_W-1:0]   scan_row,
    output logic [CHAR_W-1:0]  scan_char,
    output logic [COLOR_W-1:0] scan_color
);

    localparam int unsigned CELLS = COLS * ROWS;
    localparam int unsigned IDX_W = $clog2(CELLS);

    logic               txt_we;
    logic               clr_we;
    logic [IDX_W-1:0]   cell_off;
    logic               in_range;
    logic [IDX_W-1:0]   scan_idx;
    logic               hit_q;
    logic               primed_q;
    logic [CHAR_W-1:0]  chr_rd;
    logic [COLOR_W-1:0] clr_rd;

    txtbuf_decode #(
        .ADDR_W   (ADDR_W),
        .CELLS    (CELLS),
        .IDX_W    (IDX_W),
        .TXT_BASE (TXT_BASE),
        .CLR_BASE (CLR_BASE)
    ) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .txt_we   (txt_we),
        .clr_we   (clr_we),
        .cell_off (cell_off)
    );

    // Raster index: row-major, clamped to zero when off the grid
    always_comb begin
        in_range = ({1'b0, scan_col} < (COL_W+1)'(COLS)) &&
                   ({1'b0, scan_row} < (ROW_W+1)'(ROWS));
        scan_idx = in_range ? (IDX_W'(scan_row) * IDX_W'(COLS) + IDX_W'(scan_col)) : '0;
    end

    txtbuf_plane #(.WIDTH(CHAR_W), .DEPTH(CELLS), .IDX_W(IDX_W)) u_chr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (txt_we),
        .waddr (cell_off),
        .wdata (wr_data),
        .raddr (scan_idx),
        .rdata (chr_rd)
    );

    txtbuf_plane #(.WIDTH(COLOR_W), .DEPTH(CELLS), .IDX_W(IDX_W)) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (clr_we),
        .waddr (cell_off),
        .wdata (wr_data[COLOR_W-1:0]),
        .raddr (scan_idx),
        .rdata (clr_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q    <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            hit_q    <= in_range;
            primed_q <= 1'b1;
        end
    end

    always_comb begin
        scan_char  = hit_q ? chr_rd : '0;
        scan_color = hit_q ? clr_rd : '0;
    end

    assert_off_grid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, scan_col} >= (COL_W+1)'(COLS)) || ({1'b0, scan_row} >= (ROW_W+1)'(ROWS)))
        |=> (scan_char == '0 && scan_color == '0))
        else $error("off-grid scan returned nonzero");

    assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $stable(scan_col) && $stable(scan_row) &&
         !wr_en && !$past(wr_en))
        |=> ($stable(scan_char) && $stable(scan_color)))
        else $error("scan output moved with no cause");

endmodule

// File: tb/sim_txtbuf_top.sv
module sim_txtbuf_top;

    localparam int COLS  = 100;
    localparam int ROWS  = 75;
    localparam int CELLS = COLS * ROWS;
    localparam logic [31:0] TB_TXT = 32'h0000C000;
    localparam logic [31:0] TB_CLR = 32'h0000E000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic [6:0]  scan_col;
    logic [6:0]  scan_row;
    logic [7:0]  scan_char;
    logic [3:0]  scan_color;

    always #5 clk = ~clk;

    txtbuf_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .scan_col   (scan_col),
        .scan_row   (scan_row),
        .scan_char  (scan_char),
        .scan_color (scan_color)
    );

    typedef struct {
        int unsigned cyc;
        logic [7:0]  c;
        logic [3:0]  k;
        string       tag;
    } item_t;

    logic [7:0]  m_chr [CELLS];
    logic [3:0]  m_clr [CELLS];
    item_t       sb [$];
    item_t       mon_it;
    item_t       drv_it;
    int unsigned cyc = 0;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item whose result is due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc < cyc) begin
            mon_it = sb.pop_front();
            total++;
            if (scan_char !== mon_it.c || scan_color !== mon_it.k) begin
                bad++;
                $display("FAIL %s: char/color actual=%h/%h expected=%h/%h",
                         mon_it.tag, scan_char, scan_color, mon_it.c, mon_it.k);
            end
        end
    end

    // Driver: one bus cycle, optional scan with expectation pushed
    task automatic step(bit we, logic [31:0] a, logic [7:0] d,
                        int col, int row, string tag, bit chk);
        @(negedge clk);
        wr_en    = we;
        wr_addr  = a;
        wr_data  = d;
        scan_col = 7'(col);
        scan_row = 7'(row);
        if (chk) begin
            drv_it.cyc = cyc;
            drv_it.tag = tag;
            if (col < COLS && row < ROWS) begin
                drv_it.c = m_chr[row*COLS + col];
                drv_it.k = m_clr[row*COLS + col];
            end else begin
                drv_it.c = 8'h00;
                drv_it.k = 4'h0;
            end
            sb.push_back(drv_it);
        end
        if (we) begin
            if (a >= TB_TXT && a < TB_TXT + CELLS)
                m_chr[int'(a - TB_TXT)] = d;
            else if (a >= TB_CLR && a < TB_CLR + CELLS)
                m_clr[int'(a - TB_CLR)] = d[3:0];
        end
    endtask

    task automatic wr(logic [31:0] a, logic [7:0] d);
        step(1'b1, a, d, 0, 0, "", 1'b0);
    endtask

    task automatic rd(int col, int row, string tag);
        step(1'b0, 32'h0, 8'h00, col, row, tag, 1'b1);
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 8'h00, 0, 0, "", 1'b0);
    endtask

    task automatic check_zero(string tag);
        @(negedge clk);
        total++;
        if (scan_char !== 8'h00 || scan_color !== 4'h0) begin
            bad++;
            $display("FAIL %s: reset outputs actual=%h/%h expected=00/0",
                     tag, scan_char, scan_color);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = '0;
        wr_data  = '0;
        scan_col = '0;
        scan_row = '0;
        repeat (3) @(negedge clk);
        check_zero("R8");
        rst_n = 1'b1;

        // R1 / R2: fill both planes; color data carries a nonzero high nibble
        for (int i = 0; i < CELLS; i++) wr(TB_TXT + 32'(i), 8'((i * 7 + 3) ^ (i >> 8)));
        for (int i = 0; i < CELLS; i++) wr(TB_CLR + 32'(i), 8'(8'hA0 | 8'((i * 5 + (i >> 4)) & 15)));

        // R1 / R4: raster sweep of every cell
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                rd(c, r, "R1");

        // R4: strided access pattern
        for (int k = 0; k < 300; k++) rd((k * 37) % COLS, (k * 13) % ROWS, "R4");

        // R1 / R2: last cell of each window
        wr(32'h0000DD4B, 8'h3C);
        wr(32'h0000FD4B, 8'hF9);
        rd(99, 74, "R1");
        rd(99, 74, "R2");

        // R3: stores just outside the windows and aliased above bit 15
        wr(32'h0000BFFF, 8'h5A);
        wr(32'h0000DD4C, 8'h5A);
        wr(32'h0000DFFF, 8'h5A);
        wr(32'h0000FD4C, 8'h5A);
        wr(32'h8000C000, 8'h5A);
        wr(32'h0001E001, 8'h5A);
        wr(32'h00000000, 8'h5A);
        rd(0, 0, "R3");
        rd(1, 0, "R3");
        rd(99, 74, "R3");
        rd(98, 74, "R3");

        // R5: single-plane overwrites leave the other plane alone
        wr(TB_TXT + 32'd50, 8'hE1);
        rd(50, 0, "R5");
        wr(TB_CLR + 32'd51, 8'h0D);
        rd(51, 0, "R5");

        // R6: same-cycle store and scan of cell (10,20)
        step(1'b1, TB_TXT + 32'(20 * COLS + 10), 8'h99, 10, 20, "R6", 1'b1);
        rd(10, 20, "R6");
        step(1'b1, TB_CLR + 32'(20 * COLS + 11), 8'h06, 11, 20, "R6", 1'b1);
        rd(11, 20, "R6");

        // R7: off-grid coordinates
        rd(100, 0, "R7");
        rd(0, 75, "R7");
        rd(127, 127, "R7");
        rd(5, 5, "R7");

        // R8: mid-run reset keeps the planes
        idle();
        idle();
        @(negedge clk);
        rst_n = 1'b0;
        check_zero("R8");
        check_zero("R8");
        @(negedge clk);
        rst_n = 1'b1;
        rd(0, 0, "R8");
        rd(10, 20, "R8");
        rd(99, 74, "R8");
        rd(42, 37, "R8");
        idle();
        idle();
        idle();
        finish_run();
    end

endmodule